// File: doc/BRIEF.md
# Carry-save array multiplier

This block multiplies two unsigned operands with no clock: an M-bit multiplicand and an N-bit multiplier, giving an (M+N)-bit product. Every partial-product bit is one AND gate that pairs a multiplier bit with a multiplicand bit. The weight of that bit is the sum of the two bit indices. Both operands fan out across the whole grid.

The partial products pass through N-1 rows of adder cells. The first row is made of half adders. The later rows are made of full adders, with a half adder at the most significant edge. No row ripples its carries sideways. Each cell sends its carry down to the next row, one column to the left in weight. Each row retires one low product bit. After the last row, a separate merging row of M cells adds the leftover sum and carry vectors into the upper product bits. That merging row is the only place where a carry ripples, so the array has one dominant critical path.

A designer uses the block wherever an unsigned product is needed within a cycle's combinational budget. The parameters must satisfy M >= 2 and N >= 2.

Top module: `csm_array_mult`

## Requirements
- R1: `product_o` equals the unsigned arithmetic product of `mcand_i` and `mplier_i` for every pair of operand values.
- R2: With every operand bit set, the product is (2^M-1)(2^N-1) with no bit lost. Its most significant bit (bit M+N-1) is 1, and the merging row produces no carry beyond bit M+N-1.
- R3: Product bit 0 equals `mcand_i[0]` AND `mplier_i[0]`.
- R4: When either operand is zero, every product bit is 0, whatever the other operand holds.
- R5: When only bit k of `mplier_i` is set, the product equals `mcand_i` shifted left by k. For k = 0 the product is `mcand_i` itself.
- R6: The block is purely combinational, with no clock or reset port. A new operand pair gives its product before any clock edge follows, so two pairs applied within one clock period each give their own product.
- R7: The product is exact when the two widths differ (M not equal to N).
- R8: On a 4-by-4 instance, 12 times 5 gives 60. On a wider instance, 43 times 42 gives 1806.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | M | Unsigned multiplicand, broadcast along the array columns |
| mplier_i | input | N | Unsigned multiplier; bit i gates partial-product row i |
| product_o | output | M+N | Unsigned product; bit 0 is the AND of the two low operand bits |

## Verification
Every result of this block is due in the same cycle as its stimulus, zero clock edges later, because no register lies between the operands and the product. The bench changes operands only at a falling clock edge. It reads the product 1 ns later, well before the next rising edge. For R6 it applies two operand pairs inside one clock period and checks each one, showing that no edge is needed. Two instances are exercised: a 4-by-4 instance swept over all 256 operand pairs, and a 16-by-12 instance driven with directed corner values and random pairs.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
// Package csm_pkg
// Shared types for the carry-save array multiplier. The cell result pairs
// the carry (one weight up) with the sum (same weight).
package csm_pkg;

    typedef struct packed {
        logic carry;
        logic sum;
    } csm_cell_out_t;

endpackage

// File: rtl/csm_half_add.sv
`timescale 1ns/1ps
// Module csm_half_add
// Two-input adder cell: sum and carry of two equal-weight bits.
// Assumes nothing beyond single-bit inputs.
module csm_half_add (
    input  logic                   a_i,
    input  logic                   b_i,
    output csm_pkg::csm_cell_out_t out_o
);

    // Form the sum and the carry bit.
    always_comb begin
        out_o.sum   = a_i ^ b_i;
        out_o.carry = a_i & b_i;
    end

    // The cell output must equal the arithmetic count of set inputs (R1).
    always_comb begin
        a_r1_half_add_count: assert ({out_o.carry, out_o.sum} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("half adder count mismatch");
    end

endmodule

// File: rtl/csm_full_add.sv
`timescale 1ns/1ps
// Module csm_full_add
// Three-input adder cell: sum and carry of three equal-weight bits.
// Assumes nothing beyond single-bit inputs.
module csm_full_add (
    input  logic                   a_i,
    input  logic                   b_i,
    input  logic                   c_i,
    output csm_pkg::csm_cell_out_t out_o
);

    // Form the sum by parity and the carry by majority.
    always_comb begin
        out_o.sum   = a_i ^ b_i ^ c_i;
        out_o.carry = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end

    // The cell output must equal the arithmetic count of set inputs (R1).
    always_comb begin
        a_r1_full_add_count: assert ({out_o.carry, out_o.sum}
                                     == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i}))
            else $error("full adder count mismatch");
    end

endmodule

// File: rtl/csm_pp_gen.sv
`timescale 1ns/1ps
// Module csm_pp_gen
// Partial-product generator: row i, column j is mplier bit i AND mcand
// bit j, with weight i+j. Assumes M >= 2 and N >= 2.
module csm_pp_gen #(
    parameter int M = 8,
    parameter int N = 8
) (
    input  logic [M-1:0]          mcand_i,
    input  logic [N-1:0]          mplier_i,
    output logic [N-1:0][M-1:0]   pp_o
);

    for (genvar i = 0; i < N; i++) begin : pp_row_g
        for (genvar j = 0; j < M; j++) begin : pp_col_g
            assign pp_o[i][j] = mplier_i[i] & mcand_i[j];
        end
    end

endmodule

// File: rtl/csm_adder_row.sv
`timescale 1ns/1ps
// Module csm_adder_row
// One carry-save row. Cell j adds partial-product bit j of this row, the
// sum bit j+1 from the row above and the carry j from the row above; its
// own carry goes down to the next row rather than sideways. The first row
// (FIRST=1) receives no carries and uses half adders only. The top cell
// of every row has no upper sum input and is a half adder.
// Assumes M >= 2.
module csm_adder_row #(
    parameter int M     = 8,
    parameter bit FIRST = 1'b0
) (
    input  logic [M-1:0] pp_i,
    input  logic [M-1:1] sum_i,
    input  logic [M-1:0] carry_i,
    output logic [M-1:0] sum_o,
    output logic [M-1:0] carry_o
);

    for (genvar j = 0; j < M; j++) begin : cell_g
        csm_pkg::csm_cell_out_t cell_q;
        if (j == M - 1) begin : edge_g
            csm_half_add u_ha (
                .a_i   (pp_i[j]),
                .b_i   (carry_i[j]),
                .out_o (cell_q)
            );
        end else if (FIRST) begin : ha_g
            csm_half_add u_ha (
                .a_i   (pp_i[j]),
                .b_i   (sum_i[j+1]),
                .out_o (cell_q)
            );
        end else begin : fa_g
            csm_full_add u_fa (
                .a_i   (pp_i[j]),
                .b_i   (sum_i[j+1]),
                .c_i   (carry_i[j]),
                .out_o (cell_q)
            );
        end
        assign sum_o[j]   = cell_q.sum;
        assign carry_o[j] = cell_q.carry;
    end

    if (FIRST) begin : first_chk_g
        // The first row must see no saved carries from above (R1).
        always_comb begin
            a_r1_first_row_carry_free: assert (carry_i == '0)
                else $error("first row received carries");
        end
    end

endmodule

// File: rtl/csm_merge_row.sv
`timescale 1ns/1ps
// Module csm_merge_row
// Vector-merging row: a ripple adder that folds the last sum and carry
// vectors into the upper product bits. Cell 0 is a half adder and the
// others are full adders. Assumes W >= 2.
module csm_merge_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    for (genvar k = 0; k < W; k++) begin : bit_g
        csm_pkg::csm_cell_out_t cell_q;
        logic                   co;
        if (k == 0) begin : lsb_g
            csm_half_add u_ha (
                .a_i   (a_i[k]),
                .b_i   (b_i[k]),
                .out_o (cell_q)
            );
        end else begin : fa_g
            csm_full_add u_fa (
                .a_i   (a_i[k]),
                .b_i   (b_i[k]),
                .c_i   (bit_g[k-1].co),
                .out_o (cell_q)
            );
        end
        assign sum_o[k] = cell_q.sum;
        assign co       = cell_q.carry;
    end

    assign cout_o = bit_g[W-1].co;

    // The merged result must be the exact sum of both vectors (R2).
    always_comb begin
        a_r2_merge_exact: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("merge row sum mismatch");
    end

endmodule

// File: rtl/csm_array_mult.sv
`timescale 1ns/1ps
// Module csm_array_mult
// Unsigned carry-save array multiplier, purely combinational. Product bit
// 0 is taken straight from the first partial product. Carry-save rows 1
// to N-1 each retire one low product bit, and a merging row forms bits N
// to M+N-1. Assumes M >= 2 and N >= 2; no clock and no reset.
module csm_array_mult #(
    parameter int M = 8,
    parameter int N = 8
) (
    input  logic [M-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [M+N-1:0] product_o
);

    localparam int P = M + N;

    logic [N-1:0][M-1:0] pp;
    logic                merge_cout;

    csm_pp_gen #(.M(M), .N(N)) u_pp (
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .pp_o     (pp)
    );

    assign product_o[0] = pp[0][0];

    for (genvar r = 1; r < N; r++) begin : row_g
        logic [M-1:0] s_q;
        logic [M-1:0] c_q;
        if (r == 1) begin : top_g
            csm_adder_row #(.M(M), .FIRST(1'b1)) u_row (
                .pp_i    (pp[r]),
                .sum_i   (pp[0][M-1:1]),
                .carry_i ('0),
                .sum_o   (s_q),
                .carry_o (c_q)
            );
        end else begin : inner_g
            csm_adder_row #(.M(M), .FIRST(1'b0)) u_row (
                .pp_i    (pp[r]),
                .sum_i   (row_g[r-1].s_q[M-1:1]),
                .carry_i (row_g[r-1].c_q),
                .sum_o   (s_q),
                .carry_o (c_q)
            );
        end
        assign product_o[r] = s_q[0];
    end

    csm_merge_row #(.W(M)) u_merge (
        .a_i    ({1'b0, row_g[N-1].s_q[M-1:1]}),
        .b_i    (row_g[N-1].c_q),
        .sum_o  (product_o[P-1:N]),
        .cout_o (merge_cout)
    );

    logic [P-1:0] ref_prod;

    // Behavioural product, used only by the checks below.
    always_comb begin
        ref_prod = P'(mcand_i) * P'(mplier_i);
    end

    // Port-level checks of the array against arithmetic.
    always_comb begin
        a_r1_product_exact: assert (product_o == ref_prod)
            else $error("product differs from arithmetic product");
        a_r2_no_overflow: assert (merge_cout == 1'b0)
            else $error("merge row carried beyond product width");
        a_r3_low_bit: assert (product_o[0] == (mcand_i[0] & mplier_i[0]))
            else $error("low product bit wrong");
        if (mcand_i == '0 || mplier_i == '0) begin
            a_r4_zero_operand: assert (product_o == '0)
                else $error("zero operand gave nonzero product");
        end
        if (mplier_i == N'(1)) begin
            a_r5_unit_multiplier: assert (product_o == P'(mcand_i))
                else $error("unit multiplier did not pass multiplicand");
        end
    end

endmodule

// File: tb/csm_array_mult_test.sv
`timescale 1ns/1ps
// Directed bench for csm_array_mult: a 4x4 instance (uut) and a 16x12
// instance (uut_wide). Operands change at the falling edge and the
// product is read 1 ns later.
module csm_array_mult_test;

    localparam int SM = 4;
    localparam int SN = 4;
    localparam int WM = 16;
    localparam int WN = 12;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [SM-1:0]    a_s = '0;
    logic [SN-1:0]    b_s = '0;
    logic [SM+SN-1:0] p_s;
    logic [WM-1:0]    a_w = '0;
    logic [WN-1:0]    b_w = '0;
    logic [WM+WN-1:0] p_w;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    csm_array_mult #(.M(SM), .N(SN)) uut (
        .mcand_i (a_s), .mplier_i (b_s), .product_o (p_s)
    );

    csm_array_mult #(.M(WM), .N(WN)) uut_wide (
        .mcand_i (a_w), .mplier_i (b_w), .product_o (p_w)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_small(input int a, input int b);
        @(negedge clk);
        a_s = SM'(a);
        b_s = SN'(b);
        #1;
    endtask

    task automatic drive_wide(input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        a_w = WM'(a);
        b_w = WN'(b);
        #1;
    endtask

    // Reset phase: all-zero operands give all-zero products (R4).
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        drive_small(0, 0);
        drive_wide(0, 0);
        chk("R4 reset small", 64'(p_s), 64'd0);
        chk("R4 reset wide", 64'(p_w), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Every 4x4 pair against the arithmetic product (R1) and its low bit (R3).
    task automatic t_exhaustive;
        for (int a = 0; a < (1 << SM); a++) begin
            for (int b = 0; b < (1 << SN); b++) begin
                drive_small(a, b);
                chk("R1 exhaustive", 64'(p_s), 64'(a * b));
                chk("R3 low bit", 64'(p_s[0]), 64'((a & 1) & (b & 1)));
            end
        end
    endtask

    // All-ones operands keep every product bit (R2).
    task automatic t_extremes;
        drive_small((1 << SM) - 1, (1 << SN) - 1);
        chk("R2 small max", 64'(p_s), 64'(((1 << SM) - 1) * ((1 << SN) - 1)));
        chk("R2 small top bit", 64'(p_s[SM+SN-1]), 64'd1);
        drive_wide({64{1'b1}}, {64{1'b1}});
        chk("R2 wide max", 64'(p_w), ((64'd1 << WM) - 1) * ((64'd1 << WN) - 1));
        chk("R2 wide top bit", 64'(p_w[WM+WN-1]), 64'd1);
    endtask

    // Zero on either side gives zero whatever the other holds (R4).
    task automatic t_zero;
        drive_wide(64'hBEEF, 0);
        chk("R4 zero multiplier", 64'(p_w), 64'd0);
        drive_wide(0, 64'hABC);
        chk("R4 zero multiplicand", 64'(p_w), 64'd0);
    endtask

    // Single set multiplier bit k shifts the multiplicand by k (R5).
    task automatic t_shift;
        for (int k = 0; k < WN; k++) begin
            drive_wide(64'hC3A5, 64'd1 << k);
            chk("R5 one-hot multiplier", 64'(p_w), 64'hC3A5 << k);
        end
    endtask

    // Two operand pairs within one clock period, no edge between (R6).
    task automatic t_same_cycle;
        @(posedge clk);
        #0.5;
        a_w = WM'(1234);
        b_w = WN'(567);
        #1;
        chk("R6 first pair", 64'(p_w), 64'd1234 * 64'd567);
        a_w = WM'(999);
        b_w = WN'(4000);
        #1;
        chk("R6 second pair", 64'(p_w), 64'd999 * 64'd4000);
    endtask

    // Worked examples (R8).
    task automatic t_examples;
        drive_small(12, 5);
        chk("R8 twelve by five", 64'(p_s), 64'd60);
        drive_wide(43, 42);
        chk("R8 forty-three by forty-two", 64'(p_w), 64'd1806);
    endtask

    // Random pairs on the unequal-width instance (R7).
    task automatic t_random;
        for (int n = 0; n < 600; n++) begin
            logic [63:0] a;
            logic [63:0] b;
            a = 64'(WM'($urandom));
            b = 64'(WN'($urandom));
            drive_wide(a, b);
            chk("R7 random wide", 64'(p_w), a * b);
        end
    endtask

    initial begin
        t_reset();
        t_exhaustive();
        t_extremes();
        t_zero();
        t_shift();
        t_same_cycle();
        t_examples();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: an unfinished run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule